// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block lets a client reach 16-bit registers inside a remote region that can only be reached through a small window of 32-bit registers. The client presents one request at a time. Each request carries a read/write flag, a byte address and 16 bits of write data. The sequencer runs the required series of word accesses on a simple 32-bit register bus. That bus carries one access at a time, with a valid/acknowledge handshake. When the series ends, the sequencer returns a 16-bit result with a one-cycle done pulse and two separate failure flags.

Before it is written to the window's address register, the byte address is translated to a word index plus a fixed base. A write is a fire-and-forget series of three bus writes. A read issues the command and then polls a read-back register. The read-back word packs a ready flag, a two-bit status code and the data. Polling runs under a fixed retry budget.

States:
- `ST_IDLE`: waiting for a request.
- `ST_SET_ADDR`: writing the translated address.
- `ST_SET_DATA`: writing the data word (writes only).
- `ST_SEND_CMD`: writing the command code.
- `ST_POLL`: reading the read-back register.
- `ST_FINISH`: the done cycle.

Transitions:
- `ST_IDLE` to `ST_SET_ADDR` when a request is accepted.
- `ST_SET_ADDR` to `ST_SET_DATA` on acknowledge for a write.
- `ST_SET_ADDR` to `ST_SEND_CMD` on acknowledge for a read.
- `ST_SET_DATA` to `ST_SEND_CMD` on acknowledge.
- `ST_SEND_CMD` to `ST_FINISH` on acknowledge for a write.
- `ST_SEND_CMD` to `ST_POLL` on acknowledge for a read.
- `ST_POLL` stays in `ST_POLL` on a not-ready acknowledge while budget remains.
- `ST_POLL` to `ST_FINISH` on a ready acknowledge, or on the last not-ready acknowledge of the budget.
- `ST_FINISH` to `ST_IDLE` unconditionally.

Top module: `ind_reg_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done and bus_valid are all 0.
- R2: A request is taken only in ST_IDLE. A req_valid seen while busy is high starts no access and does not alter the bus sequence or the response of the running request. When the sequencer is idle, bus_valid is 0.
- R3: The first bus access of every request is a write to offset ADDR_OFS (default 0x10) whose 32-bit data is the byte address shifted right by one plus 0x30000.
- R4: A write request issues exactly three bus writes, in this order: the translated address to ADDR_OFS, the write data zero-extended to WDATA_OFS (default 0x14), and the value 1 to CMD_OFS (default 0x18). It issues no bus read. Its response has data 0 and both flags 0.
- R5: A read request writes the translated address to ADDR_OFS, then writes the value 2 to CMD_OFS, then issues bus reads of RDATA_OFS (default 0x1C).
- R6: Once bus_valid is high without bus_ack, bus_valid, bus_write, bus_addr and bus_wdata stay unchanged in the next cycle.
- R7: Polling stops at the first read-back word with bit 18 (ready) set. If bits 17:16 (status) of that word equal 1, rsp_data is bits 15:0 of the word and both flags are 0.
- R8: A ready word whose status is 0 (no response), 2 (request failed) or 3 (response error) gives rsp_data 0xFFFF, rsp_err 1 and rsp_timeout 0.
- R9: After POLL_LIMIT (default 32) consecutive not-ready reads, no further read is issued. The response is rsp_data 0xFFFF, rsp_timeout 1, rsp_err 0. A ready word on read number POLL_LIMIT is still honoured.
- R10: busy rises in the cycle after acceptance and stays high up to and including the done cycle. done is high for exactly one cycle: the cycle after the final bus acknowledge. rsp_data, rsp_err and rsp_timeout are valid while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W | Byte address in the remote region |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Read result (0xFFFF on failure, 0 for writes) |
| rsp_timeout | output | 1 | Poll budget exhausted |
| rsp_err | output | 1 | Ready word carried a status other than OK |
| bus_valid | output | 1 | Bus access request |
| bus_write | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | BUS_AW | Window register offset |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus acknowledge, completes the access this cycle |
| bus_rdata | input | 32 | Bus read data, valid with bus_ack |

## Verification
A wrong state encoding or a wrong transition shows up first on the bus. The result can be a missing or reordered window access, a read issued during a write request, or a poll that starts before the command. These show up within a few cycles of acceptance, and the bench sees them in its per-request bus log. A miscounted poll budget changes the number of reads by one at the 32-read boundary. The boundary tests use 31 and 32 not-ready words to expose it. A wrong status decode is visible only in rsp_data and the flags during the done cycle, so every status code is driven directly.

// File: rtl/irs_pkg.sv
package irs_pkg;

    localparam int BUS_DW = 32;
    localparam int REG_DW = 16;

    localparam logic [BUS_DW-1:0] XLATE_BASE = 32'h0003_0000;
    localparam logic [BUS_DW-1:0] CMD_WRITE  = 32'd1;
    localparam logic [BUS_DW-1:0] CMD_READ   = 32'd2;

    localparam int RDY_BIT = 18;
    localparam int STAT_LO = 16;

    localparam logic [REG_DW-1:0] FAIL_WORD = 16'hFFFF;

    typedef enum logic [1:0] {
        RS_NORESP  = 2'd0,
        RS_OK      = 2'd1,
        RS_REQFAIL = 2'd2,
        RS_RSPERR  = 2'd3
    } irs_status_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SET_ADDR,
        ST_SET_DATA,
        ST_SEND_CMD,
        ST_POLL,
        ST_FINISH
    } irs_state_e;

endpackage

// File: rtl/irs_addr_xlate.sv
module irs_addr_xlate
    import irs_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] byte_addr,
    output logic [BUS_DW-1:0] word_val
);
    logic [ADDR_W-1:0] half_addr;
    logic [BUS_DW-1:0] half_ext;

    assign half_addr = byte_addr >> 1;

    generate
        if (ADDR_W < BUS_DW) begin : g_pad
            assign half_ext = {{(BUS_DW-ADDR_W){1'b0}}, half_addr};
        end else begin : g_trunc
            assign half_ext = half_addr[BUS_DW-1:0];
        end
    endgenerate

    assign word_val = half_ext + XLATE_BASE;

endmodule

// File: rtl/irs_rdata_decode.sv
module irs_rdata_decode
    import irs_pkg::*;
(
    input  logic [BUS_DW-1:0] rdata,
    output logic              ready,
    output logic              status_ok,
    output logic [REG_DW-1:0] field
);
    irs_status_e status;

    always_comb begin
        ready     = rdata[RDY_BIT];
        status    = irs_status_e'(rdata[STAT_LO+1:STAT_LO]);
        status_ok = (status == RS_OK);
        field     = rdata[REG_DW-1:0];
    end

endmodule

// File: rtl/irs_poll_ctr.sv
module irs_poll_ctr #(
    parameter int POLL_LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int CNT_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POLL_LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (step && cnt_q != CNT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == CNT_LAST);

endmodule

// File: rtl/irs_bus_drv.sv
module irs_bus_drv
    import irs_pkg::*;
#(
    parameter int                BUS_AW    = 8,
    parameter logic [BUS_AW-1:0] ADDR_OFS  = 8'h10,
    parameter logic [BUS_AW-1:0] WDATA_OFS = 8'h14,
    parameter logic [BUS_AW-1:0] CMD_OFS   = 8'h18,
    parameter logic [BUS_AW-1:0] RDATA_OFS = 8'h1C
) (
    input  irs_state_e        state,
    input  logic              is_write,
    input  logic [BUS_DW-1:0] xaddr,
    input  logic [REG_DW-1:0] wdata,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [BUS_DW-1:0] bus_wdata
);
    always_comb begin
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state)
            ST_SET_ADDR: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = ADDR_OFS;
                bus_wdata = xaddr;
            end
            ST_SET_DATA: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = WDATA_OFS;
                bus_wdata = {{(BUS_DW-REG_DW){1'b0}}, wdata};
            end
            ST_SEND_CMD: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = CMD_OFS;
                bus_wdata = is_write ? CMD_WRITE : CMD_READ;
            end
            ST_POLL: begin
                bus_valid = 1'b1;
                bus_write = 1'b0;
                bus_addr  = RDATA_OFS;
            end
            ST_IDLE, ST_FINISH: begin
                bus_valid = 1'b0;
            end
            default: begin
                bus_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ind_reg_seq.sv
module ind_reg_seq
    import irs_pkg::*;
#(
    parameter int                ADDR_W     = 17,
    parameter int                BUS_AW     = 8,
    parameter int                POLL_LIMIT = 32,
    parameter logic [BUS_AW-1:0] ADDR_OFS   = 8'h10,
    parameter logic [BUS_AW-1:0] WDATA_OFS  = 8'h14,
    parameter logic [BUS_AW-1:0] CMD_OFS    = 8'h18,
    parameter logic [BUS_AW-1:0] RDATA_OFS  = 8'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rsp_data,
    output logic              rsp_timeout,
    output logic              rsp_err,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata
);
    irs_state_e state_q, state_d;

    logic              wr_q;
    logic [BUS_DW-1:0] xaddr_q;
    logic [REG_DW-1:0] wdata_q;
    logic [BUS_DW-1:0] xaddr_new;

    logic              accept;
    logic              xfer;
    logic              rd_ready;
    logic              rd_ok;
    logic [REG_DW-1:0] rd_field;
    logic              poll_last;
    logic              poll_clear;
    logic              poll_step;

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign xfer   = bus_valid && bus_ack;

    irs_addr_xlate #(.ADDR_W(ADDR_W)) u_xlate (
        .byte_addr (req_addr),
        .word_val  (xaddr_new)
    );

    irs_rdata_decode u_decode (
        .rdata     (bus_rdata),
        .ready     (rd_ready),
        .status_ok (rd_ok),
        .field     (rd_field)
    );

    assign poll_clear = (state_q != ST_POLL);
    assign poll_step  = (state_q == ST_POLL) && xfer && !rd_ready;

    irs_poll_ctr #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (poll_clear),
        .step  (poll_step),
        .last  (poll_last)
    );

    irs_bus_drv #(
        .BUS_AW    (BUS_AW),
        .ADDR_OFS  (ADDR_OFS),
        .WDATA_OFS (WDATA_OFS),
        .CMD_OFS   (CMD_OFS),
        .RDATA_OFS (RDATA_OFS)
    ) u_drv (
        .state     (state_q),
        .is_write  (wr_q),
        .xaddr     (xaddr_q),
        .wdata     (wdata_q),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = ST_SET_ADDR;
            ST_SET_ADDR: if (xfer)   state_d = wr_q ? ST_SET_DATA : ST_SEND_CMD;
            ST_SET_DATA: if (xfer)   state_d = ST_SEND_CMD;
            ST_SEND_CMD: if (xfer)   state_d = wr_q ? ST_FINISH : ST_POLL;
            ST_POLL:     if (xfer && (rd_ready || poll_last)) state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q        <= 1'b0;
            xaddr_q     <= '0;
            wdata_q     <= '0;
            rsp_data    <= '0;
            rsp_timeout <= 1'b0;
            rsp_err     <= 1'b0;
        end else begin
            if (accept) begin
                wr_q    <= req_write;
                xaddr_q <= xaddr_new;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_SEND_CMD && xfer && wr_q) begin
                rsp_data    <= '0;
                rsp_timeout <= 1'b0;
                rsp_err     <= 1'b0;
            end else if (state_q == ST_POLL && xfer) begin
                if (rd_ready) begin
                    rsp_data    <= rd_ok ? rd_field : FAIL_WORD;
                    rsp_err     <= !rd_ok;
                    rsp_timeout <= 1'b0;
                end else if (poll_last) begin
                    rsp_data    <= FAIL_WORD;
                    rsp_err     <= 1'b0;
                    rsp_timeout <= 1'b1;
                end
            end
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_FINISH);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !busy && !done && !bus_valid); // R1
    AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !bus_valid); // R2
    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> bus_valid && bus_write && bus_addr == ADDR_OFS); // R3
    AST_WRITE_NO_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_write |-> !wr_q && bus_addr == RDATA_OFS); // R5
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ack |=> bus_valid && $stable(bus_write) && $stable(bus_addr) && $stable(bus_wdata)); // R6
    AST_ERR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        done && rsp_err |-> rsp_data == FAIL_WORD && !rsp_timeout); // R8
    AST_TIMEOUT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        done && rsp_timeout |-> rsp_data == FAIL_WORD && !rsp_err); // R9
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) accept |=> busy); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done && !busy); // R10

endmodule

// File: tb/tb_ind_reg_seq.sv
module tb_ind_reg_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 17;
    localparam int BUS_AW = 8;
    localparam int POLL_LIMIT = 32;
    localparam logic [7:0] OFS_ADDR = 8'h10;
    localparam logic [7:0] OFS_WDATA = 8'h14;
    localparam logic [7:0] OFS_CMD = 8'h18;
    localparam logic [7:0] OFS_RDATA = 8'h1C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic busy, done, rsp_timeout, rsp_err;
    logic [15:0] rsp_data;
    logic bus_valid, bus_write;
    logic [BUS_AW-1:0] bus_addr;
    logic [31:0] bus_wdata;
    logic bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ind_reg_seq #(
        .ADDR_W(ADDR_W), .BUS_AW(BUS_AW), .POLL_LIMIT(POLL_LIMIT),
        .ADDR_OFS(OFS_ADDR), .WDATA_OFS(OFS_WDATA), .CMD_OFS(OFS_CMD), .RDATA_OFS(OFS_RDATA)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rsp_data(rsp_data), .rsp_timeout(rsp_timeout), .rsp_err(rsp_err),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_xaddr(input logic [ADDR_W-1:0] a);
        return {15'd0, a >> 1} + 32'h0003_0000;
    endfunction

    function automatic logic [15:0] exp_data(input logic [31:0] w);
        return (w[17:16] == 2'd1) ? w[15:0] : 16'hFFFF;
    endfunction

    // Bus slave model with transaction log
    int          nr_count = 0;
    logic [31:0] final_word = '0;
    int          rd_idx = 0;
    int          log_n = 0;
    logic        log_wr [64];
    logic [7:0]  log_addr [64];
    logic [31:0] log_data [64];
    int          wait_left = 0;
    bit          prev_pend = 0;
    logic        p_wr;
    logic [7:0]  p_addr;
    logic [31:0] p_data;
    bit          slave_on = 0;

    always @(negedge clk) begin
        if (slave_on && prev_pend) begin
            check(bus_valid && bus_write == p_wr && bus_addr == p_addr && bus_wdata == p_data,
                  "R6", "bus hold", {bus_valid, bus_write, 22'd0, bus_addr}, {1'b1, p_wr, 22'd0, p_addr});
        end
        prev_pend = 0;
        bus_ack = 1'b0;
        if (slave_on && bus_valid) begin
            if (wait_left == 0) begin
                bus_ack = 1'b1;
                if (log_n < 64) begin
                    log_wr[log_n] = bus_write;
                    log_addr[log_n] = bus_addr;
                    log_data[log_n] = bus_wdata;
                end
                log_n++;
                if (!bus_write) begin
                    if (rd_idx < nr_count) bus_rdata = $urandom & ~32'h0004_0000;
                    else bus_rdata = final_word;
                    rd_idx++;
                end
                wait_left = $urandom_range(0, 2);
            end else begin
                wait_left--;
                prev_pend = 1;
                p_wr = bus_write;
                p_addr = bus_addr;
                p_data = bus_wdata;
            end
        end
    end

    task automatic run_req(input bit wr, input logic [ADDR_W-1:0] a, input logic [15:0] wd,
                           input int nr, input logic [31:0] fw, input bit stray);
        int cyc;
        int exp_reads;
        bit to_exp;
        logic [15:0] e_data;
        logic e_err;
        nr_count = nr;
        final_word = fw | 32'h0004_0000;
        rd_idx = 0;
        log_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1, "R10", "busy after accept", {31'd0, busy}, 1);
        cyc = 0;
        while (done !== 1'b1 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (done === 1'b1) begin
                req_valid = 1'b0;
            end else if (stray) begin
                req_valid = $urandom_range(0, 1);
                req_write = $urandom_range(0, 1);
                req_addr = $urandom;
                req_wdata = $urandom;
            end
        end
        check(done === 1'b1, "R10", "done seen", {31'd0, done}, 1);
        to_exp = !wr && nr >= POLL_LIMIT;
        if (wr) begin
            e_data = 16'h0000; e_err = 0;
        end else if (to_exp) begin
            e_data = 16'hFFFF; e_err = 0;
        end else begin
            e_data = exp_data(final_word); e_err = (final_word[17:16] != 2'd1);
        end
        check(rsp_data === e_data, wr ? "R4" : (to_exp ? "R9" : (e_err ? "R8" : "R7")),
              "rsp_data", {16'd0, rsp_data}, {16'd0, e_data});
        check(rsp_err === e_err, e_err ? "R8" : "R7", "rsp_err", {31'd0, rsp_err}, {31'd0, e_err});
        check(rsp_timeout === to_exp, "R9", "rsp_timeout", {31'd0, rsp_timeout}, {31'd0, to_exp});
        @(negedge clk);
        req_valid = 1'b0;
        check(done === 1'b0 && busy === 1'b0, "R10", "done one cycle", {30'd0, done, busy}, 0);
        @(negedge clk);
        check(bus_valid === 1'b0, "R2", "no access after done", {31'd0, bus_valid}, 0);
        // Bus log
        exp_reads = wr ? 0 : (to_exp ? POLL_LIMIT : nr + 1);
        check(log_n == (wr ? 3 : 2 + exp_reads), wr ? "R4" : "R9", "access count", log_n, wr ? 3 : 2 + exp_reads);
        check(log_wr[0] && log_addr[0] == OFS_ADDR && log_data[0] == exp_xaddr(a),
              "R3", "address write", log_data[0], exp_xaddr(a));
        if (wr) begin
            check(log_wr[1] && log_addr[1] == OFS_WDATA && log_data[1] == {16'd0, wd},
                  "R4", "data write", log_data[1], {16'd0, wd});
            check(log_wr[2] && log_addr[2] == OFS_CMD && log_data[2] == 32'd1,
                  "R4", "write command", log_data[2], 32'd1);
        end else begin
            check(log_wr[1] && log_addr[1] == OFS_CMD && log_data[1] == 32'd2,
                  "R5", "read command", log_data[1], 32'd2);
            for (int i = 2; i < log_n && i < 64; i++) begin
                check(!log_wr[i] && log_addr[i] == OFS_RDATA, "R5", "poll read",
                      {23'd0, log_wr[i], log_addr[i]}, {24'd0, OFS_RDATA});
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R1", "busy in reset", {31'd0, busy}, 0);
        check(done === 1'b0, "R1", "done in reset", {31'd0, done}, 0);
        check(bus_valid === 1'b0, "R1", "bus_valid in reset", {31'd0, bus_valid}, 0);
        rst_n = 1'b1;
        slave_on = 1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && bus_valid === 1'b0, "R1", "after reset",
              {29'd0, busy, done, bus_valid}, 0);
        // Directed cases
        run_req(1, 17'h1_2345, 16'hBEEF, 0, 0, 0);
        run_req(0, 17'h0_0000, 16'h0, 0, 32'h0001_A5A5, 0);
        run_req(0, 17'h1_FFFF, 16'h0, 3, 32'h0000_1234, 0);
        run_req(0, 17'h0_0102, 16'h0, 1, 32'h0002_1234, 0);
        run_req(0, 17'h0_0103, 16'h0, 2, 32'h0003_1234, 0);
        run_req(0, 17'h0_4000, 16'h0, POLL_LIMIT - 1, 32'h0001_C3C3, 0);
        run_req(0, 17'h0_4002, 16'h0, POLL_LIMIT, 32'h0001_C3C3, 0);
        run_req(1, 17'h0_0010, 16'h1111, 0, 0, 1);
        run_req(0, 17'h0_0020, 16'h0, 2, 32'h0001_7777, 1);
        // Random mix
        for (int k = 0; k < 40; k++) begin
            run_req($urandom_range(0, 1), ADDR_W'($urandom), 16'($urandom),
                    $urandom_range(0, 36), {14'd0, 2'($urandom_range(0, 3)), 16'($urandom)},
                    bit'($urandom_range(0, 1)));
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule